// File: doc/BRIEF.md
# Watchdog Timer with Selectable Time Base

This block is a watchdog timer that sits in a byte-wide runtime register window. Software writes an 8-bit timeout value. The timer then counts down on a one-second tick, either directly (seconds base) or through a divide-by-N prescaler (minutes base, N = 60 by default). When the count reaches zero the timer stops and raises a sticky expiry flag. Software must clear that flag by hand.

Keyboard and mouse activity pulses can each be enabled to restart a running count from the last value written. The expiry flag drives the watchdog pin only while a pin-routing field selects the watchdog function. The logic that turns the pin into a system reset is outside this block.

All register writes take effect at the clock edge on which `reg_we` is high. Read data is combinational from the addressed register.

Top module: `wdt_unit`

## Requirements
- R1: After reset, the registers at 0x47, 0x65, 0x66, 0x67 and 0x68 all read 0x00, and `wdt_pin` is low.
- R2: The registers at 0x47 (pin routing), 0x65 (time base) and 0x67 (activity enables) read back the full byte last written.
- R3: A nonzero write to 0x66 loads the down-counter with that value, including when it is already running. Reading 0x66 returns the remaining count. With 0x65 bit 7 = 1 (seconds base), each `sec_tick` pulse lowers the count by one.
- R4: With 0x65 bit 7 = 0 (minutes base), the count drops by one on every TICKS_PER_MIN-th `sec_tick` after the load.
- R5: Writing 0x00 to 0x66 stops the timer. After that, no number of ticks changes the count or sets the expiry flag.
- R6: When the count steps from one to zero, 0x68 bit 0 becomes 1. The count then stays at zero on further ticks.
- R7: 0x68 bit 0 is sticky. Writing 0x68 with bit 0 = 1 leaves it unchanged. Writing 0x68 with bit 0 = 0 clears it.
- R8: When 0x67 bit 1 = 1, a `kbd_act` pulse reloads a running counter with the last value written to 0x66. When that bit is 0, the pulse is ignored.
- R9: When 0x67 bit 2 = 1, a `mouse_act` pulse reloads a running counter with the last value written to 0x66. When that bit is 0, the pulse is ignored.
- R10: `wdt_pin` equals 0x68 bit 0 when 0x47 bits 3:0 equal 0xE. For any other value of those bits, `wdt_pin` is low.
- R11: Activity pulses do not restart a timer that has already expired. The count stays at zero and the flag stays set.
- R12: Addresses outside the five registers read 0x00, and 0x68 bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sec_tick | input | 1 | One-second tick enable, one cycle wide |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| wdt_pin | output | 1 | Watchdog output pin, active high |

## Verification
The bench builds the block with TICKS_PER_MIN = 4, so that every prescaler phase of a minutes-base countdown can be walked tick by tick. It sweeps the timeout over 1 to 6 in the seconds base and over 1 to 3 in the minutes base, reading the remaining count before every tick. It also covers all 32 pin-routing codes formed by the low nibble together with a clear or set upper nibble. The small divisor puts the divide-by-N rollover and the step from one to zero within reach in a few hundred cycles.

// File: rtl/wdt_unit_pkg.sv
package wdt_unit_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] ADDR_PINMUX = 8'h47;
    localparam logic [7:0] ADDR_UNIT   = 8'h65;
    localparam logic [7:0] ADDR_VALUE  = 8'h66;
    localparam logic [7:0] ADDR_WAKE   = 8'h67;
    localparam logic [7:0] ADDR_STATUS = 8'h68;

    localparam int unsigned UNIT_SEC_BIT = 7;
    localparam int unsigned KBD_EN_BIT   = 1;
    localparam int unsigned MOUSE_EN_BIT = 2;
    localparam int unsigned FIRED_BIT    = 0;

    localparam logic [3:0] PIN_SEL_WDT = 4'hE;

    typedef struct packed {
        logic unit_sec;
        logic kbd_en;
        logic mouse_en;
        logic pin_on;
    } wdt_cfg_t;

    typedef struct packed {
        logic              load;
        logic [BYTE_W-1:0] value;
    } wdt_load_t;

    function automatic logic pin_routed(input logic [BYTE_W-1:0] mux);
        return mux[3:0] == PIN_SEL_WDT;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cnt,
    input  logic              fired,
    output wdt_cfg_t          cfg,
    output wdt_load_t         load,
    output logic [BYTE_W-1:0] reload_val,
    output logic              clr_req,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] pinmux_q, unit_q, wake_q, reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pinmux_q <= '0;
            unit_q   <= '0;
            wake_q   <= '0;
            reload_q <= '0;
        end else if (we) begin
            case (addr)
                ADDR_PINMUX: pinmux_q <= wdata;
                ADDR_UNIT:   unit_q   <= wdata;
                ADDR_WAKE:   wake_q   <= wdata;
                ADDR_VALUE:  reload_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.unit_sec = unit_q[UNIT_SEC_BIT];
        cfg.kbd_en   = wake_q[KBD_EN_BIT];
        cfg.mouse_en = wake_q[MOUSE_EN_BIT];
        cfg.pin_on   = pin_routed(pinmux_q);
        load.load    = we && (addr == ADDR_VALUE);
        load.value   = wdata;
        reload_val   = reload_q;
        clr_req      = we && (addr == ADDR_STATUS) && !wdata[FIRED_BIT];
    end

    always_comb begin
        case (addr)
            ADDR_PINMUX: rdata = pinmux_q;
            ADDR_UNIT:   rdata = unit_q;
            ADDR_VALUE:  rdata = cnt;
            ADDR_WAKE:   rdata = wake_q;
            ADDR_STATUS: rdata = {{(BYTE_W-1){1'b0}}, fired};
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned DIV = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    input  logic bypass,
    input  logic restart,
    output logic step
);

    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);
    assign step = tick && active && (bypass || wrap);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (tick && active && !bypass) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

    // R4
    pre_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PRE_LAST);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wdt_load_t         load,
    input  logic              reload_req,
    input  logic [BYTE_W-1:0] reload_val,
    input  logic              step,
    input  logic              clr_req,
    output logic [BYTE_W-1:0] cnt,
    output logic              fired,
    output logic              active,
    output logic              restart
);

    logic reload_hit, expire;

    assign active     = (cnt != '0);
    assign reload_hit = reload_req && active && !load.load;
    assign restart    = load.load || reload_hit;
    assign expire     = step && (cnt == BYTE_W'(1)) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load.load) begin
            cnt <= load.value;
        end else if (reload_hit) begin
            cnt <= reload_val;
        end else if (step && active) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fired <= 1'b0;
        end else if (expire) begin
            fired <= 1'b1;
        end else if (clr_req) begin
            fired <= 1'b0;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1));

    // R6
    fire_from_one_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fired) |-> $past(cnt) == BYTE_W'(1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) && !load.load |=> cnt == '0);

endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
    import wdt_unit_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sec_tick,
    input  logic       kbd_act,
    input  logic       mouse_act,
    output logic       wdt_pin
);

    wdt_cfg_t          cfg;
    wdt_load_t         load;
    logic [BYTE_W-1:0] reload_val, cnt;
    logic              clr_req, fired, active, restart, step, reload_req;

    assign reload_req = (kbd_act && cfg.kbd_en) || (mouse_act && cfg.mouse_en);
    assign wdt_pin    = fired && cfg.pin_on;

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cnt(cnt), .fired(fired), .cfg(cfg), .load(load),
        .reload_val(reload_val), .clr_req(clr_req), .rdata(reg_rdata)
    );

    wdt_prescale #(.DIV(TICKS_PER_MIN)) u_pre (
        .clk(clk), .rst(rst), .tick(sec_tick), .active(active),
        .bypass(cfg.unit_sec), .restart(restart), .step(step)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst(rst), .load(load), .reload_req(reload_req),
        .reload_val(reload_val), .step(step), .clr_req(clr_req),
        .cnt(cnt), .fired(fired), .active(active), .restart(restart)
    );

    // R10
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_pin |-> fired);

endmodule

// File: tb/wdt_unit_test.sv
module wdt_unit_test;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0, kbd_act = 1'b0, mouse_act = 1'b0;
    logic       wdt_pin;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wdt_unit #(.TICKS_PER_MIN(DIV)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .kbd_act(kbd_act), .mouse_act(mouse_act), .wdt_pin(wdt_pin)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 check(tag, int'(reg_rdata), exp);
    endtask

    task automatic pin_is(input int exp, input string tag);
        @(negedge clk);
        #1 check(tag, int'(wdt_pin), exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic kbd_pulse();
        @(negedge clk); kbd_act = 1'b1;
        @(negedge clk); kbd_act = 1'b0;
    endtask

    task automatic mouse_pulse();
        @(negedge clk); mouse_act = 1'b1;
        @(negedge clk); mouse_act = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] pats [4] = '{8'h00, 8'hA5, 8'h5A, 8'hFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h47, 0, "R1 pinmux"); rd(8'h65, 0, "R1 unit");
        rd(8'h66, 0, "R1 value"); rd(8'h67, 0, "R1 wake");
        rd(8'h68, 0, "R1 status"); pin_is(0, "R1 pin");

        // R2 readback
        foreach (pats[i]) begin
            wr(8'h47, pats[i]); rd(8'h47, pats[i], "R2 pinmux");
            wr(8'h65, pats[i]); rd(8'h65, pats[i], "R2 unit");
            wr(8'h67, pats[i]); rd(8'h67, pats[i], "R2 wake");
        end
        wr(8'h67, 8'h00);

        // R12 unmapped addresses
        rd(8'h00, 0, "R12 addr00"); rd(8'h10, 0, "R12 addr10");
        rd(8'h69, 0, "R12 addr69"); rd(8'hFF, 0, "R12 addrFF");

        // R3 R6 R7 R10 seconds base sweep
        wr(8'h47, 8'h0E);
        wr(8'h65, 8'h80);
        for (int n = 1; n <= 6; n++) begin
            wr(8'h66, 8'(n));
            for (int k = 0; k < n; k++) begin
                rd(8'h66, n - k, "R3 seconds count");
                rd(8'h68, 0, "R6 not yet fired");
                ticks(1);
            end
            rd(8'h66, 0, "R6 count at zero");
            rd(8'h68, 1, "R6 fired");
            pin_is(1, "R10 pin routed");
            ticks(2);
            rd(8'h66, 0, "R6 stays stopped");
            wr(8'h68, 8'h01);
            rd(8'h68, 1, "R7 write one keeps flag");
            wr(8'h68, 8'hFE);
            rd(8'h68, 0, "R7 write zero clears, R12 upper bits");
            pin_is(0, "R10 pin low after clear");
        end

        // R3 rewrite while running
        wr(8'h66, 8'd7); ticks(3);
        rd(8'h66, 4, "R3 running");
        wr(8'h66, 8'd9);
        rd(8'h66, 9, "R3 reload by rewrite");

        // R4 minutes base sweep
        wr(8'h65, 8'h00);
        for (int n = 1; n <= 3; n++) begin
            wr(8'h66, 8'(n));
            for (int j = 0; j < n * DIV; j++) begin
                rd(8'h66, n - j / DIV, "R4 minutes count");
                rd(8'h68, 0, "R4 not yet fired");
                ticks(1);
            end
            rd(8'h66, 0, "R4 count at zero");
            rd(8'h68, 1, "R4 fired");
            wr(8'h68, 8'h00);
        end

        // R5 disable by zero write
        wr(8'h65, 8'h80);
        wr(8'h66, 8'd5); ticks(2);
        wr(8'h66, 8'd0);
        rd(8'h66, 0, "R5 stopped");
        ticks(10);
        rd(8'h66, 0, "R5 count stays");
        rd(8'h68, 0, "R5 no fire");
        pin_is(0, "R5 pin low");

        // R8 R9 activity reload
        wr(8'h67, 8'h02);
        wr(8'h66, 8'd5); ticks(3);
        rd(8'h66, 2, "R8 before kbd");
        kbd_pulse();
        rd(8'h66, 5, "R8 kbd reload");
        ticks(1);
        mouse_pulse();
        rd(8'h66, 4, "R9 mouse ignored when disabled");
        wr(8'h67, 8'h04);
        kbd_pulse();
        rd(8'h66, 4, "R8 kbd ignored when disabled");
        mouse_pulse();
        rd(8'h66, 5, "R9 mouse reload");

        // R11 no restart after expiry
        wr(8'h67, 8'h06);
        ticks(5);
        rd(8'h68, 1, "R11 fired");
        kbd_pulse(); mouse_pulse();
        rd(8'h66, 0, "R11 count stays zero");
        rd(8'h68, 1, "R11 flag stays");

        // R10 pin routing sweep with flag set
        for (int v = 0; v < 32; v++) begin
            wr(8'h47, (v >= 16 ? 8'hF0 : 8'h00) | 8'(v % 16));
            pin_is((v % 16) == 14 ? 1 : 0, "R10 pin routing");
        end
        wr(8'h68, 8'h00);
        wr(8'h47, 8'h0E);
        pin_is(0, "R10 pin low with flag clear");

        summary();
        $finish;
    end

endmodule